// File: doc/BRIEF.md
# In-System Programming Access Gate

This block sits behind a JTAG TAP controller and holds two test data registers that decide whether the device may be programmed through the test port. The first is a single-bit reset register. While it holds a 1 the device is kept in reset, as if the external reset pin were pulled low. Its value feeds the reset request with no update latch, so a 1 shifted in takes effect in the very next cycle. When the bit returns to 0, a countdown holds reset asserted for a further number of clocks given on an input. If the bit is set again during the countdown, the countdown starts over.

The second register is a programming-unlock key with a shift stage and an update stage. Bits enter through the shift stage during Shift-DR. The update stage takes the shift stage's value at Update-DR. Programming is allowed only while the update stage equals one fixed signature, 0xA370 by default. Power-on reset clears the key. A separate clear input, pulsed when programming mode is left, also clears it.

The TAP controller is outside this block. It supplies one-cycle shift and update enables plus one select line per register, all synchronous to the block clock.

Top module: `isp_gate`

## Requirements
- R1: After power-on reset (rst_n low), dev_reset, pgm_enabled and tdo are all 0.
- R2: A clock edge with sel_rst=1, shift_en=1 and tdi=1 makes dev_reset 1 from that edge on, with no update strobe needed.
- R3: While the reset register holds 1, dev_reset stays 1 whatever the update strobe, the timeout value or the other register do.
- R4: After the reset register is shifted back to 0, dev_reset stays 1 for exactly tmo_len further clock cycles and then falls to 0. With tmo_len=0 it falls in the same cycle the bit clears.
- R5: If the reset register is set to 1 again before the countdown ends, the countdown restarts, and the full tmo_len is counted again after the next release.
- R6: The key register is 16 bits wide and shifts least significant bit first. On each enabled shift, tdi enters bit 15 and bit 0 leaves. While sel_pen=1, tdo shows bit 0 of the shift stage.
- R7: pgm_enabled is 1 only while the update stage equals 16'hA370. Any other value, including values one bit away from it, gives 0.
- R8: Shift-stage contents never affect pgm_enabled. It changes only on an update strobe with sel_pen=1, or on a clear.
- R9: pgm_exit=1 at a clock edge clears the update stage to 0. It wins over an update strobe in the same cycle.
- R10: Shift and update strobes with neither select asserted change neither register.
- R11: tdo shows the reset bit when sel_rst=1, bit 0 of the key shift stage when sel_pen=1, and 0 when neither is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; TAP strobes and the countdown run on it |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sel_rst | input | 1 | Instruction decode selects the reset register |
| sel_pen | input | 1 | Instruction decode selects the key register |
| shift_en | input | 1 | One-cycle Shift-DR enable |
| update_en | input | 1 | One-cycle Update-DR enable |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected register |
| tmo_len | input | 16 | Countdown length in clocks after reset release |
| pgm_exit | input | 1 | Clears the key when programming mode is left |
| dev_reset | output | 1 | Device reset request, active high |
| pgm_enabled | output | 1 | Programming unlocked |

## Verification
The hardest case to reach is a countdown that is restarted partway through. The stimulus releases the reset bit, waits a few cycles inside the countdown, sets and clears the bit again, and then measures how long dev_reset stays high after the second release. A second hard case is a shift stage that already holds the signature while no update has happened. The bench shifts the exact key in, checks that programming stays locked, then issues an unselected update and a clear that races an update, and checks pgm_enabled after each.

// File: rtl/isp_gate_pkg.sv
`timescale 1ns/1ps
package isp_gate_pkg;
   localparam int unsigned KEY_W_DEFAULT = 16;
   localparam logic [15:0] KEY_SIG_DEFAULT = 16'hA370;

   typedef enum logic [1:0] {
      TDR_NONE = 2'd0,
      TDR_RST  = 2'd1,
      TDR_KEY  = 2'd2
   } tdr_sel_e;
endpackage

// File: rtl/isp_gate_rstreg.sv
`timescale 1ns/1ps
module isp_gate_rstreg #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             shift_en,
   input  logic             tdi,
   input  logic [TMO_W-1:0] tmo_len,
   output logic             bit_q,
   output logic             reset_req
);
   if (TMO_W < 1) begin : g_bad_tmo_w
      $error("isp_gate_rstreg: TMO_W must be at least 1");
   end

   logic [TMO_W-1:0] hold_cnt;

   // Single-stage register; its value is used directly, with no update latch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bit_q <= 1'b0;
      else if (sel && shift_en)  bit_q <= tdi;
   end

   // While the bit is set, keep reloading; once clear, count down to zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hold_cnt <= '0;
      else if (bit_q)             hold_cnt <= tmo_len;
      else if (hold_cnt != '0)    hold_cnt <= hold_cnt - TMO_W'(1);
   end

   assign reset_req = bit_q | (hold_cnt != '0);

   assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shift_en && tdi) |=> reset_req);

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q |=> (hold_cnt == $past(tmo_len)));

   assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reset_req && !(sel && shift_en && tdi)) |=> !reset_req);
endmodule

// File: rtl/isp_gate_keyreg.sv
`timescale 1ns/1ps
module isp_gate_keyreg #(
   parameter int unsigned      KEY_W     = 16,
   parameter logic [KEY_W-1:0] KEY_SIG   = 16'hA370,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic shift_en,
   input  logic update_en,
   input  logic clear,
   input  logic tdi,
   output logic tdo_bit,
   output logic unlocked
);
   if (KEY_W < 2) begin : g_bad_key_w
      $error("isp_gate_keyreg: KEY_W must be at least 2");
   end

   logic [KEY_W-1:0] shf_q;
   logic [KEY_W-1:0] shf_d;
   logic [KEY_W-1:0] upd_q;

   if (LSB_FIRST) begin : g_lsb_first
      assign shf_d   = {tdi, shf_q[KEY_W-1:1]};
      assign tdo_bit = shf_q[0];
   end else begin : g_msb_first
      assign shf_d   = {shf_q[KEY_W-2:0], tdi};
      assign tdo_bit = shf_q[KEY_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shf_q <= '0;
      else if (sel && shift_en)  shf_q <= shf_d;
   end

   // Clear has priority over an update in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 upd_q <= '0;
      else if (clear)             upd_q <= '0;
      else if (sel && update_en)  upd_q <= shf_q;
   end

   assign unlocked = (upd_q == KEY_SIG);

   assert_update_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(sel && update_en)) |=> $stable(unlocked));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !unlocked);
endmodule

// File: rtl/isp_gate.sv
`timescale 1ns/1ps
module isp_gate #(
   parameter int unsigned      TMO_W   = 16,
   parameter int unsigned      KEY_W   = isp_gate_pkg::KEY_W_DEFAULT,
   parameter logic [KEY_W-1:0] KEY_SIG = isp_gate_pkg::KEY_SIG_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_rst,
   input  logic             sel_pen,
   input  logic             shift_en,
   input  logic             update_en,
   input  logic             tdi,
   output logic             tdo,
   input  logic [TMO_W-1:0] tmo_len,
   input  logic             pgm_exit,
   output logic             dev_reset,
   output logic             pgm_enabled
);
   import isp_gate_pkg::*;

   logic     rst_bit;
   logic     key_tdo;
   tdr_sel_e cur_sel;

   isp_gate_rstreg #(.TMO_W(TMO_W)) u_rstreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_rst),
      .shift_en  (shift_en),
      .tdi       (tdi),
      .tmo_len   (tmo_len),
      .bit_q     (rst_bit),
      .reset_req (dev_reset)
   );

   isp_gate_keyreg #(.KEY_W(KEY_W), .KEY_SIG(KEY_SIG), .LSB_FIRST(1'b1)) u_keyreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_pen),
      .shift_en  (shift_en),
      .update_en (update_en),
      .clear     (pgm_exit),
      .tdi       (tdi),
      .tdo_bit   (key_tdo),
      .unlocked  (pgm_enabled)
   );

   always_comb begin
      if (sel_rst)      cur_sel = TDR_RST;
      else if (sel_pen) cur_sel = TDR_KEY;
      else              cur_sel = TDR_NONE;
   end

   always_comb begin
      unique case (cur_sel)
         TDR_RST: tdo = rst_bit;
         TDR_KEY: tdo = key_tdo;
         default: tdo = 1'b0;
      endcase
   end

   assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rst, sel_pen}));

   assert_hold_while_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rst && tdo) |-> dev_reset);
endmodule

// File: tb/isp_gate_test.sv
`timescale 1ns/1ps
module isp_gate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_rst = 1'b0, sel_pen = 1'b0;
   logic        shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0, pgm_exit = 1'b0;
   logic [15:0] tmo_len = 16'd0;
   logic        tdo, dev_reset, pgm_enabled;

   int vectors = 0;
   int fails = 0;

   always #2 clk = ~clk;

   isp_gate uut (
      .clk(clk), .rst_n(rst_n), .sel_rst(sel_rst), .sel_pen(sel_pen),
      .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
      .tmo_len(tmo_len), .pgm_exit(pgm_exit), .dev_reset(dev_reset),
      .pgm_enabled(pgm_enabled)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next one.
   task automatic tick(input logic s, input logic u, input logic d, input logic clr);
      shift_en = s; update_en = u; tdi = d; pgm_exit = clr;
      @(negedge clk);
      shift_en = 1'b0; update_en = 1'b0; tdi = 1'b0; pgm_exit = 1'b0;
   endtask

   task automatic shift_key(input logic [15:0] v);
      for (int i = 0; i < 16; i++) tick(1'b1, 1'b0, v[i], 1'b0);
   endtask

   task automatic count_hold(output int n);
      n = 0;
      while (dev_reset && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      check("R1 dev_reset", dev_reset, 0);
      check("R1 pgm_enabled", pgm_enabled, 0);
      check("R1 tdo", tdo, 0);
   endtask

   task automatic t_reset_reg();
      int n;
      sel_rst = 1'b1; tmo_len = 16'd5;
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      check("R2 immediate reset", dev_reset, 1);
      check("R11 tdo shows reset bit", tdo, 1);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      tmo_len = 16'd0;
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      check("R3 held while set", dev_reset, 1);
      tmo_len = 16'd5;
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      count_hold(n);
      check("R4 timeout length 5", n, 5);
      tmo_len = 16'd0;
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      check("R4 zero timeout releases at once", dev_reset, 0);
      sel_rst = 1'b0;
   endtask

   task automatic t_restart();
      int n;
      sel_rst = 1'b1; tmo_len = 16'd6;
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5 still in countdown", dev_reset, 1);
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      count_hold(n);
      check("R5 full count after restart", n, 6);
      sel_rst = 1'b0;
   endtask

   task automatic t_key();
      sel_pen = 1'b1;
      shift_key(16'hA370);
      check("R8 shift stage alone does not unlock", pgm_enabled, 0);
      check("R6 tdo is bit 0 of shift stage", tdo, 0);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      check("R7 signature unlocks", pgm_enabled, 1);
      shift_key(16'h0005);
      check("R6 tdo after shifting 0x0005", tdo, 1);
      check("R8 shifting keeps unlock", pgm_enabled, 1);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      check("R7 other value locks", pgm_enabled, 0);
      shift_key(16'hA371);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      check("R7 near miss 0xA371 locks", pgm_enabled, 0);
      shift_key(16'hA370);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0, 1'b1);
      check("R9 clear locks", pgm_enabled, 0);
      tick(1'b0, 1'b1, 1'b0, 1'b1);
      check("R9 clear wins over update", pgm_enabled, 0);
      sel_pen = 1'b0;
      check("R11 tdo zero with no select", tdo, 0);
   endtask

   task automatic t_unselected();
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      check("R10 unselected shift leaves reset bit", dev_reset, 0);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      check("R10 unselected update leaves key", pgm_enabled, 0);
      sel_pen = 1'b1;
      check("R10 key shift stage untouched", tdo, 0);
      tick(1'b0, 1'b1, 1'b0, 1'b0);
      check("R10 selected update then unlocks", pgm_enabled, 1);
      sel_pen = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_reset_reg();
      t_restart();
      t_key();
      t_unselected();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule